// File: doc/BRIEF.md
# Host-to-Mezzanine Bus Cycle Bridge

The bridge sits between a single-master host bus and a 16-bit mezzanine module bus with several module slots. When the host selects the module region, the bridge decodes the target slot and one of four spaces: memory, I/O, ID, or interrupt acknowledge. It then runs one module bus cycle, timed by a module clock enable. The host cycle is held open until the module acknowledges, so the module cycle sits inside the host cycle. Data passes straight across, with per-space rules for width and byte lanes.

Each slot has its own select strobe for each space. A module that stays silent for too long ends the host cycle with a bus error rather than hanging it. Module interrupt request lines are passed through untouched to an interrupt controller. Software can also read a vector from a chosen slot by addressing the interrupt-acknowledge space.

Top module: `mzb_bridge`

## Requirements
- R1: After reset no select strobe is asserted, mod_wr is low, and hst_done and hst_berr are low.
- R2: The host address is decoded by fields. Bits [23:22] give the space: 0 memory, 1 I/O, 2 ID, 3 interrupt acknowledge. Bits [21:20] give the slot. Bits [19:1] give the module word address mod_addr. During a cycle exactly one strobe is asserted: the addressed space's strobe for the addressed slot. The vector {intsel, idsel, iosel, memsel} is one-hot.
- R3: A memory-space cycle is always a 16-bit word transfer. mod_be is 2'b11 even when hst_byte is set, mod_wdata equals hst_wdata, and hst_rdata returns the full module word.
- R4: An I/O or ID cycle with hst_byte low transfers a word (mod_be 2'b11). With hst_byte high, address bit 0 selects the lane: 0 gives the upper lane (mod_be 2'b10), 1 gives the lower lane (mod_be 2'b01). A byte write puts hst_wdata[7:0] on both lanes. A byte read returns the selected module byte in hst_rdata[7:0], with the upper byte zero.
- R5: Strobes rise on the first module clock-enable tick after hst_sel. They stay stable between ticks. A module acknowledge is taken on a tick. hst_done is asserted for exactly one cycle, in the clock cycle after the one in which the acknowledging tick was sampled, and hst_rdata is valid with it.
- R6: If no acknowledge arrives by the 64th tick of an asserted strobe, the cycle ends with a one-cycle hst_berr and no hst_done. An acknowledge on exactly the 64th tick completes normally.
- R7: An interrupt-acknowledge cycle asserts only the slot's intsel strobe, with mod_be 2'b01. It never drives mod_wr high, even for a host write. It returns the module's mod_rdata[7:0] in hst_rdata[7:0], with the upper byte zero.
- R8: irq_out equals mod_irq at all times. There are two lines per slot, with slot s on bits [2s+1:2s].
- R9: After a completed cycle, no new module cycle starts until hst_sel has been low for at least one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hst_sel | input | 1 | Host selects module region, held until done or error |
| hst_addr | input | 24 | Host byte address |
| hst_wr | input | 1 | Host write |
| hst_byte | input | 1 | Host byte-sized access |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Read data to host |
| hst_done | output | 1 | One-cycle completion |
| hst_berr | output | 1 | One-cycle bus error (timeout) |
| mod_ce | input | 1 | Module bus clock enable tick |
| mod_addr | output | 19 | Module word address |
| mod_be | output | 2 | Byte enables, bit 1 upper lane |
| mod_wr | output | 1 | Module write strobe qualifier |
| mod_wdata | output | 16 | Module write data |
| mod_rdata | input | 16 | Module read data |
| mod_ack | input | 1 | Module acknowledge |
| mod_memsel | output | 4 | Memory-space select per slot |
| mod_iosel | output | 4 | I/O-space select per slot |
| mod_idsel | output | 4 | ID-space select per slot |
| mod_intsel | output | 4 | Interrupt-acknowledge select per slot |
| mod_irq | input | 8 | Module interrupt requests |
| irq_out | output | 8 | Requests to interrupt controller |

## Verification
The hardest situation to reach is the timeout boundary. The bridge must accept an acknowledge on the 64th tick but raise a bus error when the acknowledge would come one tick later. The bench therefore plays the module itself: it generates the clock-enable ticks, counts the ticks while a strobe is asserted, and raises the acknowledge on a chosen tick number. Directed runs with the acknowledge on tick 64, on tick 65, and never, sit alongside random accesses with short delays. Those random accesses sweep every space, slot, lane and direction.

// File: rtl/mzb_pkg.sv
package mzb_pkg;
    typedef enum logic [1:0] {
        SP_MEM  = 2'd0,
        SP_IO   = 2'd1,
        SP_ID   = 2'd2,
        SP_IACK = 2'd3
    } space_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_STRB,
        ST_RESP,
        ST_HOLD
    } state_e;
endpackage

// File: rtl/mzb_decode.sv
module mzb_decode
    import mzb_pkg::*;
#(
    parameter int AW     = 24,
    parameter int SLOT_W = 2,
    parameter int DW     = 16,
    localparam int MAW   = AW - 3 - SLOT_W
) (
    input  logic [AW-1:0]     addr,
    input  logic              byte_acc,
    input  logic [DW-1:0]     wdata,
    output space_e            space,
    output logic [SLOT_W-1:0] slot,
    output logic [MAW-1:0]    waddr,
    output logic [1:0]        be,
    output logic [DW-1:0]     lane_wdata
);
    always_comb begin
        space = space_e'(addr[AW-1 -: 2]);
        slot  = addr[AW-3 -: SLOT_W];
        waddr = addr[MAW:1];
        if (space == SP_MEM || (space != SP_IACK && !byte_acc)) begin
            be         = 2'b11;
            lane_wdata = wdata;
        end else if (space == SP_IACK) begin
            be         = 2'b01;
            lane_wdata = wdata;
        end else begin
            be         = addr[0] ? 2'b01 : 2'b10;
            lane_wdata = {wdata[DW/2-1:0], wdata[DW/2-1:0]};
        end
    end
endmodule

// File: rtl/mzb_seq.sv
module mzb_seq
    import mzb_pkg::*;
#(
    parameter int TMO  = 64,
    localparam int CW  = (TMO > 2) ? $clog2(TMO) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic ce,
    input  logic ack,
    output logic latch,
    output logic strb_on,
    output logic capture,
    output logic done,
    output logic berr
);
    typedef struct packed {
        state_e        st;
        logic [CW-1:0] cnt;
        logic          err;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d       = q;
        latch   = 1'b0;
        capture = 1'b0;
        case (q.st)
            ST_IDLE: if (sel) begin
                d.st  = ST_ARM;
                latch = 1'b1;
            end
            ST_ARM: if (ce) begin
                d.st  = ST_STRB;
                d.cnt = '0;
                d.err = 1'b0;
            end
            ST_STRB: if (ce) begin
                if (ack) begin
                    capture = 1'b1;
                    d.st    = ST_RESP;
                end else if (q.cnt == CW'(TMO - 1)) begin
                    d.st  = ST_RESP;
                    d.err = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_RESP: d.st = ST_HOLD;
            ST_HOLD: if (!sel) d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
        strb_on = (q.st == ST_STRB);
        done    = (q.st == ST_RESP) && !q.err;
        berr    = (q.st == ST_RESP) && q.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, err: 1'b0};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/mzb_bridge.sv
module mzb_bridge
    import mzb_pkg::*;
#(
    parameter int AW      = 24,
    parameter int SLOT_W  = 2,
    parameter int IRQ_PER = 2,
    parameter int TMO     = 64,
    localparam int DW     = 16,
    localparam int NSLOT  = 1 << SLOT_W,
    localparam int MAW    = AW - 3 - SLOT_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hst_sel,
    input  logic [AW-1:0]            hst_addr,
    input  logic                     hst_wr,
    input  logic                     hst_byte,
    input  logic [DW-1:0]            hst_wdata,
    output logic [DW-1:0]            hst_rdata,
    output logic                     hst_done,
    output logic                     hst_berr,
    input  logic                     mod_ce,
    output logic [MAW-1:0]           mod_addr,
    output logic [1:0]               mod_be,
    output logic                     mod_wr,
    output logic [DW-1:0]            mod_wdata,
    input  logic [DW-1:0]            mod_rdata,
    input  logic                     mod_ack,
    output logic [NSLOT-1:0]         mod_memsel,
    output logic [NSLOT-1:0]         mod_iosel,
    output logic [NSLOT-1:0]         mod_idsel,
    output logic [NSLOT-1:0]         mod_intsel,
    input  logic [NSLOT*IRQ_PER-1:0] mod_irq,
    output logic [NSLOT*IRQ_PER-1:0] irq_out
);
    typedef struct packed {
        space_e            space;
        logic [SLOT_W-1:0] slot;
        logic [MAW-1:0]    waddr;
        logic [1:0]        be;
        logic              wr;
        logic [DW-1:0]     wdata;
        logic [DW-1:0]     rdata;
    } req_t;

    req_t              q, d;
    space_e            dec_space;
    logic [SLOT_W-1:0] dec_slot;
    logic [MAW-1:0]    dec_waddr;
    logic [1:0]        dec_be;
    logic [DW-1:0]     dec_wdata;
    logic              latch, strb_on, capture;
    logic [DW-1:0]     rd_fmt;

    mzb_decode #(.AW(AW), .SLOT_W(SLOT_W), .DW(DW)) u_dec (
        .addr       (hst_addr),
        .byte_acc   (hst_byte),
        .wdata      (hst_wdata),
        .space      (dec_space),
        .slot       (dec_slot),
        .waddr      (dec_waddr),
        .be         (dec_be),
        .lane_wdata (dec_wdata)
    );

    mzb_seq #(.TMO(TMO)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (hst_sel),
        .ce      (mod_ce),
        .ack     (mod_ack),
        .latch   (latch),
        .strb_on (strb_on),
        .capture (capture),
        .done    (hst_done),
        .berr    (hst_berr)
    );

    always_comb begin
        case (q.be)
            2'b10:   rd_fmt = {{(DW/2){1'b0}}, mod_rdata[DW-1:DW/2]};
            2'b01:   rd_fmt = {{(DW/2){1'b0}}, mod_rdata[DW/2-1:0]};
            default: rd_fmt = mod_rdata;
        endcase
        d = q;
        if (latch) begin
            d.space = dec_space;
            d.slot  = dec_slot;
            d.waddr = dec_waddr;
            d.be    = dec_be;
            d.wr    = hst_wr && (dec_space != SP_IACK);
            d.wdata = dec_wdata;
        end
        if (capture) begin
            d.rdata = rd_fmt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{space: SP_MEM, slot: '0, waddr: '0, be: 2'b00,
                   wr: 1'b0, wdata: '0, rdata: '0};
        end else begin
            q <= d;
        end
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic hit;
        assign hit           = strb_on && (q.slot == SLOT_W'(s));
        assign mod_memsel[s] = hit && (q.space == SP_MEM);
        assign mod_iosel[s]  = hit && (q.space == SP_IO);
        assign mod_idsel[s]  = hit && (q.space == SP_ID);
        assign mod_intsel[s] = hit && (q.space == SP_IACK);
    end

    assign mod_addr  = q.waddr;
    assign mod_be    = q.be;
    assign mod_wr    = strb_on && q.wr;
    assign mod_wdata = q.wdata;
    assign hst_rdata = q.rdata;
    assign irq_out   = mod_irq;
endmodule

// File: rtl/mzb_bridge_chk.sv
module mzb_bridge_chk #(
    parameter int NSLOT = 4,
    parameter int TMO   = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hst_done,
    input logic             hst_berr,
    input logic             mod_ce,
    input logic             mod_wr,
    input logic [1:0]       mod_be,
    input logic [NSLOT-1:0] mod_memsel,
    input logic [NSLOT-1:0] mod_iosel,
    input logic [NSLOT-1:0] mod_idsel,
    input logic [NSLOT-1:0] mod_intsel
);
    localparam int KW = $clog2(TMO + 2);
    logic [4*NSLOT-1:0] strb;
    logic [KW-1:0]      ticks;

    assign strb = {mod_intsel, mod_idsel, mod_iosel, mod_memsel};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ticks <= '0;
        else if (!(|strb)) ticks <= '0;
        else if (mod_ce) ticks <= ticks + 1'b1;
    end

    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strb));
    assert_mem_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|mod_memsel) |-> (mod_be == 2'b11));
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hst_done |=> !hst_done);
    assert_strobe_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|strb) && !mod_ce) |=> $stable(strb));
    assert_end_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hst_done && hst_berr));
    assert_tmo_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|strb) |-> (ticks < KW'(TMO)));
    assert_iack_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|mod_intsel) |-> !mod_wr);
endmodule

bind mzb_bridge mzb_bridge_chk #(.NSLOT(NSLOT), .TMO(TMO)) u_chk (.*);

// File: tb/sim_mzb_bridge.sv
module sim_mzb_bridge;
    localparam int AW = 24, MAW = 19, NS = 4, NIRQ = 8, TMO = 64;

    logic clk = 1'b0, rst_n = 1'b0;
    logic hst_sel = 0, hst_wr = 0, hst_byte = 0;
    logic [AW-1:0] hst_addr = '0;
    logic [15:0] hst_wdata = '0, hst_rdata, mod_wdata, mod_rdata = '0;
    logic hst_done, hst_berr, mod_ce = 0, mod_wr, mod_ack = 0;
    logic [MAW-1:0] mod_addr;
    logic [1:0] mod_be;
    logic [NS-1:0] mod_memsel, mod_iosel, mod_idsel, mod_intsel;
    logic [NIRQ-1:0] mod_irq = '0, irq_out;

    int n_chk = 0, n_bad = 0, cyc = 0, ce_ph = 0, tickn = 0;
    int ack_dly = 0, ack_cyc = 0, strb_cycles = 0;
    bit got_ack = 0;
    logic [15:0] rec_strb, rec_wdata;
    logic [MAW-1:0] rec_addr;
    logic [1:0] rec_be;
    logic rec_wr;
    wire [15:0] strb_all = {mod_intsel, mod_idsel, mod_iosel, mod_memsel};

    mzb_bridge u0 (.*);

    always #10 clk = ~clk;

    function automatic [15:0] mdl(input [MAW-1:0] a);
        return {a[7:0], a[15:8]} ^ 16'hA55A ^ {13'h0, a[18:16]};
    endfunction

    always @(negedge clk) begin
        cyc++;
        ce_ph   = (ce_ph == 5) ? 0 : ce_ph + 1;
        mod_ce  = (ce_ph == 0);
        mod_ack = 1'b0;
        if (|strb_all) begin
            strb_cycles++;
            if (mod_ce) begin
                tickn++;
                if (ack_dly != 0 && tickn == ack_dly) begin
                    mod_ack   = 1'b1;
                    mod_rdata = mdl(mod_addr);
                    rec_strb  = strb_all;
                    rec_addr  = mod_addr;
                    rec_be    = mod_be;
                    rec_wr    = mod_wr;
                    rec_wdata = mod_wdata;
                    ack_cyc   = cyc;
                    got_ack   = 1'b1;
                end
            end
        end else begin
            tickn = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input [31:0] act, input [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, expv);
        end
    endtask

    task automatic access(input [1:0] sp, input [1:0] sl, input [MAW-1:0] wa,
                          input bit ln, input bit by, input bit wr,
                          input [15:0] wd, input int dly, input int hold);
        bit dn = 0, be_ = 0;
        int done_cyc = 0, lim = 0;
        logic [15:0] m, erd, ewd;
        logic [1:0] ebe;
        ack_dly = dly;
        got_ack = 0;
        @(negedge clk); #1;
        hst_addr = {sp, sl, wa, ln}; hst_byte = by; hst_wr = wr; hst_wdata = wd;
        hst_sel = 1'b1;
        while (!dn && !be_ && lim < 2000) begin
            @(negedge clk); #1;
            lim++;
            dn  = hst_done;
            be_ = hst_berr;
            done_cyc = cyc;
        end
        m = mdl(wa);
        if (sp == 2'd0 || (sp != 2'd3 && !by)) begin ebe = 2'b11; erd = m; ewd = wd; end
        else if (sp == 2'd3) begin ebe = 2'b01; erd = {8'h0, m[7:0]}; ewd = wd; end
        else if (!ln) begin ebe = 2'b10; erd = {8'h0, m[15:8]}; ewd = {wd[7:0], wd[7:0]}; end
        else begin ebe = 2'b01; erd = {8'h0, m[7:0]}; ewd = {wd[7:0], wd[7:0]}; end
        if (dly == 0 || dly > TMO) begin
            chk(be_ && !dn, "R6 timeout berr", {be_, dn}, 2'b10);
        end else begin
            chk(dn && !be_, "R5 done", {dn, be_}, 2'b10);
            chk(got_ack && done_cyc == ack_cyc + 1, "R5 done timing", done_cyc, ack_cyc + 1);
            chk(rec_strb == (16'h1 << (sp * 4 + sl)), "R2 strobe", rec_strb, 16'h1 << (sp * 4 + sl));
            chk(rec_addr == wa, "R2 addr", rec_addr, wa);
            chk(rec_be == ebe, sp == 2'd0 ? "R3 be" : (sp == 2'd3 ? "R7 be" : "R4 be"), rec_be, ebe);
            chk(rec_wr == (wr && sp != 2'd3), sp == 2'd3 ? "R7 no write" : "R2 wr", rec_wr, wr && sp != 2'd3);
            if (wr && sp != 2'd3)
                chk(rec_wdata == ewd, sp == 2'd0 ? "R3 wdata" : "R4 wdata", rec_wdata, ewd);
            if (!wr)
                chk(hst_rdata == erd, sp == 2'd0 ? "R3 rdata" : (sp == 2'd3 ? "R7 rdata" : "R4 rdata"), hst_rdata, erd);
        end
        @(negedge clk); #1;
        chk(!hst_done && !hst_berr, "R5 single pulse", {hst_done, hst_berr}, 0);
        if (hold > 0) begin
            int sc = strb_cycles;
            repeat (hold) @(negedge clk);
            #1;
            chk(strb_cycles == sc && !hst_done, "R9 no restart", strb_cycles - sc, 0);
        end
        hst_sel = 1'b0;
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(strb_all == 0 && !mod_wr && !hst_done && !hst_berr, "R1 reset",
            {strb_all, mod_wr, hst_done, hst_berr}, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(strb_all == 0 && !hst_done, "R1 after release", strb_all, 0);

        access(2'd0, 2'd1, 19'h12345, 1'b1, 1'b1, 1'b0, 16'h0, 2, 0);
        access(2'd0, 2'd2, 19'h00F0F, 1'b0, 1'b1, 1'b1, 16'hBEEF, 1, 0);
        access(2'd1, 2'd0, 19'h00101, 1'b0, 1'b1, 1'b0, 16'h0, 3, 0);
        access(2'd1, 2'd3, 19'h00102, 1'b1, 1'b1, 1'b0, 16'h0, 1, 0);
        access(2'd2, 2'd2, 19'h7FFFF, 1'b0, 1'b1, 1'b1, 16'h1234, 2, 0);
        access(2'd2, 2'd1, 19'h00033, 1'b0, 1'b0, 1'b1, 16'hCAFE, 1, 0);
        access(2'd3, 2'd3, 19'h00000, 1'b0, 1'b0, 1'b1, 16'hFFFF, 1, 0);
        access(2'd3, 2'd0, 19'h00007, 1'b0, 1'b0, 1'b0, 16'h0, 4, 0);
        access(2'd1, 2'd1, 19'h00AAA, 1'b0, 1'b0, 1'b0, 16'h0, TMO, 0);
        access(2'd1, 2'd1, 19'h00AAB, 1'b0, 1'b0, 1'b0, 16'h0, TMO + 1, 0);
        access(2'd0, 2'd0, 19'h00001, 1'b0, 1'b0, 1'b0, 16'h0, 0, 0);
        access(2'd0, 2'd3, 19'h0ABCD, 1'b0, 1'b0, 1'b0, 16'h0, 1, 30);

        void'($urandom(32'h5EED));
        for (int i = 0; i < 40; i++) begin
            logic [7:0] iv;
            access(2'($urandom), 2'($urandom), 19'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom), 16'($urandom), 1 + ($urandom % 5), 0);
            iv = 8'($urandom);
            mod_irq = iv;
            #1;
            chk(irq_out == iv, "R8 irq pass", irq_out, iv);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=%h exp=%h", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule